// File: doc/BRIEF.md
# Byte-Wide Split Register Access Port

This block sits between an 8-bit microcontroller bus and a 16-bit control and status pair. One group address serves two registers. A write to that address lands in a 16-bit interrupt-enable (mode) register. A read from the same address returns a 16-bit status word. The two bytes of each register are reached through a byte pointer, not through an extra address line. Bit 0 of the pointer picks the lane, and it flips after every group access. Software therefore loads the pointer with 0x00 and issues two back-to-back writes to fill both halves. To touch only the upper half, it loads 0x01 and issues a single write.

Bus traffic never stalls the status producers. The block combines each status half with its enable half to form two interrupt requests and one merged request. The upper half serves the demodulator and the lower half serves the FEC. Status and interrupts only count while the PLL lock input is high.

Top module: `byte_reg_port`

## Requirements
- R1: After reset the mode register is all zeros, so every interrupt output is low, and the pointer is 0x00, so the first group read returns status bits [7:0].
- R2: A write (bus_wr=1) at group address 3'b010 loads bus_wdata into mode bits [7:0] when pointer bit 0 is 0, and into mode bits [15:8] when it is 1. The other half is left unchanged.
- R3: Every group access flips pointer bit 0 at the clock edge that completes it. This holds for a write and for a read alike, so two writes in a row fill the low half and then the high half.
- R4: A write at pointer address 3'b001 loads the whole pointer. Loading 0x01 and then writing once changes only mode bits [15:8].
- R5: A read (bus_rd=1, bus_wr=0) at the group address with pll_lock high returns status_in[7:0] on bus_rdata in the same cycle when pointer bit 0 is 0, and returns status_in[15:8] when it is 1.
- R6: With pll_lock low, a group read returns 0x00, and the pointer still flips.
- R7: irq_fec is high when pll_lock is high and any bit of status_in[7:0] AND mode[7:0] is set. irq_demod is formed the same way from bits [15:8]. irq_any is the OR of the two. All three are low while pll_lock is low.
- R8: An access at any address other than 3'b001 or 3'b010 changes neither the mode register nor the pointer.
- R9: bus_rdata is 0x00 in every cycle that is not a group read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data byte |
| status_in | input | 16 | Status bits; [15:8] demodulator, [7:0] FEC |
| pll_lock | input | 1 | Status validity qualifier |
| irq_demod | output | 1 | Demodulator interrupt request |
| irq_fec | output | 1 | FEC interrupt request |
| irq_any | output | 1 | Merged interrupt request |

## Verification
Read data is combinational: it is valid during the read cycle itself, so the bench samples it one nanosecond after driving the strobe on a falling edge. The pointer flip and the mode load take effect at the next rising edge, so every later access and interrupt check falls at least half a cycle after that edge. The interrupt outputs are combinational in status, lock and the registered mode. The bench changes status on a falling edge and samples the interrupts one nanosecond later, sweeping a one-hot status bit across all sixteen positions to read back every mode bit.

// File: rtl/brp_pkg.sv
package brp_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;

  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } lane_e;
endpackage

// File: rtl/brp_rst_sync.sv
module brp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/brp_ptr_ctrl.sv
module brp_ptr_ctrl
  import brp_pkg::*;
#(
  parameter int          ADDR_W     = 3,
  parameter int          DATA_W     = BYTE_W,
  parameter logic [ADDR_W-1:0] GROUP_ADDR = 3'b010,
  parameter logic [ADDR_W-1:0] PTR_ADDR   = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic              grp_wr,
  output logic              grp_rd,
  output lane_e             lane
);
  logic [DATA_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;
  logic              ptr_wr, grp_acc;

  always_comb begin
    ptr_wr  = wr && (addr == PTR_ADDR);
    grp_acc = (wr || rd) && (addr == GROUP_ADDR);
    grp_wr  = wr && (addr == GROUP_ADDR);
    grp_rd  = rd && !wr && (addr == GROUP_ADDR);
    ptr_en  = ptr_wr || grp_acc;
    ptr_d   = ptr_q;
    if (ptr_wr)       ptr_d    = wdata;
    else if (grp_acc) ptr_d[0] = ~ptr_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign lane = lane_e'(ptr_q[0]);

  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_acc && !ptr_wr) |=> (ptr_q[0] != $past(ptr_q[0])));

  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !rd) |=> $stable(ptr_q));
endmodule

// File: rtl/brp_mode_reg.sv
module brp_mode_reg
  import brp_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int NLANE  = LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    grp_wr,
  input  lane_e                   lane,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W*NLANE-1:0] mode_q
);
  localparam int WIDTH = DATA_W * NLANE;
  logic [NLANE-1:0] lane_en;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_comb lane_en[g] = grp_wr && (int'(lane) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mode_q[g*DATA_W +: DATA_W] <= '0;
      else if (lane_en[g]) mode_q[g*DATA_W +: DATA_W] <= wdata;
    end
  end

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_wr |=> $stable(mode_q));

  p_lo_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_wr && lane == LANE_LO) |=> $stable(mode_q[WIDTH-1:DATA_W]));
endmodule

// File: rtl/brp_status_rd.sv
module brp_status_rd
  import brp_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic                grp_rd,
  input  lane_e               lane,
  input  logic                lock,
  input  logic [2*DATA_W-1:0] status,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel   = (lane == LANE_HI) ? status[2*DATA_W-1:DATA_W] : status[DATA_W-1:0];
    rdata = (grp_rd && lock) ? sel : '0;
  end
endmodule

// File: rtl/brp_irq_merge.sv
module brp_irq_merge
  import brp_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  parameter int NLANE  = LANES
) (
  input  logic [DATA_W*NLANE-1:0] status,
  input  logic [DATA_W*NLANE-1:0] mode,
  input  logic                    lock,
  output logic [NLANE-1:0]        irq_lane,
  output logic                    irq_all
);
  for (genvar g = 0; g < NLANE; g++) begin : g_irq
    always_comb irq_lane[g] = lock &&
      |(status[g*DATA_W +: DATA_W] & mode[g*DATA_W +: DATA_W]);
  end

  always_comb irq_all = |irq_lane;
endmodule

// File: rtl/byte_reg_port.sv
module byte_reg_port
  import brp_pkg::*;
#(
  parameter int                ADDR_W     = 3,
  parameter logic [ADDR_W-1:0] GROUP_ADDR = 3'b010,
  parameter logic [ADDR_W-1:0] PTR_ADDR   = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] status_in,
  input  logic              pll_lock,
  output logic              irq_demod,
  output logic              irq_fec,
  output logic              irq_any
);
  logic              rst_sync_n;
  logic              grp_wr, grp_rd;
  lane_e             lane;
  logic [WORD_W-1:0] mode_q;
  logic [LANES-1:0]  irq_lane;

  brp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  brp_ptr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W),
                 .GROUP_ADDR(GROUP_ADDR), .PTR_ADDR(PTR_ADDR)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .addr(bus_addr), .wdata(bus_wdata),
    .wr(bus_wr), .rd(bus_rd), .grp_wr(grp_wr), .grp_rd(grp_rd), .lane(lane));

  brp_mode_reg #(.DATA_W(BYTE_W), .NLANE(LANES)) u_mode (
    .clk(clk), .rst_n(rst_sync_n), .grp_wr(grp_wr), .lane(lane),
    .wdata(bus_wdata), .mode_q(mode_q));

  brp_status_rd #(.DATA_W(BYTE_W)) u_rd (
    .grp_rd(grp_rd), .lane(lane), .lock(pll_lock), .status(status_in),
    .rdata(bus_rdata));

  brp_irq_merge #(.DATA_W(BYTE_W), .NLANE(LANES)) u_irq (
    .status(status_in), .mode(mode_q), .lock(pll_lock),
    .irq_lane(irq_lane), .irq_all(irq_any));

  assign irq_fec   = irq_lane[0];
  assign irq_demod = irq_lane[1];

  p_irq_lock_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pll_lock |-> !(irq_any || irq_fec || irq_demod));

  p_rd_lock_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && !pll_lock) |-> (bus_rdata == '0));

  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/byte_reg_port_tb_top.sv
`timescale 1ns/1ps
module byte_reg_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_rdata;
  logic [15:0] status_in;
  logic        pll_lock;
  logic        irq_demod, irq_fec, irq_any;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_mode;
  logic        exp_ptr0;

  always #2.5 clk = ~clk;

  byte_reg_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .status_in(status_in), .pll_lock(pll_lock),
    .irq_demod(irq_demod), .irq_fec(irq_fec), .irq_any(irq_any));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_bus(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 3'b001) exp_ptr0 = d[0];
    else if (a == 3'b010) begin
      if (exp_ptr0) exp_mode[15:8] = d; else exp_mode[7:0] = d;
      exp_ptr0 = ~exp_ptr0;
    end
  endtask

  task automatic rd_bus(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    if (a == 3'b010) exp_ptr0 = ~exp_ptr0;
  endtask

  // Reads back every mode bit via a one-hot status sweep (R7)
  task automatic sweep_mode(input string tag);
    logic [15:0] m;
    m = 16'h0;
    for (int i = 0; i < 16; i++) begin
      status_in = 16'h1 << i;
      #1;
      m[i] = (i < 8) ? irq_fec : irq_demod;
      if (irq_any !== (irq_fec | irq_demod)) chk({tag, " R7 any"}, {15'h0, irq_any}, {15'h0, irq_fec | irq_demod});
    end
    chk(tag, m, exp_mode);
  endtask

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    status_in = 16'hFFFF; pll_lock = 1'b1;
    exp_mode = '0; exp_ptr0 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    #1 chk("R1 irq_any after reset", {15'h0, irq_any}, 16'h0);
    chk("R9 rdata idle", {8'h0, bus_rdata}, 16'h0);
    status_in = 16'hA55A;
    rd_bus(3'b010, d);
    chk("R1 first read is low byte", {8'h0, d}, 16'h005A);
    wr_bus(3'b001, 8'h00);

    // R2/R3: low then high writes, several patterns
    for (int k = 0; k < 4; k++) begin
      wr_bus(3'b001, 8'h00);
      wr_bus(3'b010, 8'(8'h11 * (k + 1)));
      wr_bus(3'b010, 8'(8'hC3 ^ (k * 37)));
      sweep_mode("R2 R3 two-write fill");
    end

    // R4: upper-only write
    wr_bus(3'b001, 8'h01);
    wr_bus(3'b010, 8'h5E);
    sweep_mode("R4 upper-only write");

    // R5 and R3 (reads toggle): status sweep
    pll_lock = 1'b1;
    wr_bus(3'b001, 8'h00);
    for (int v = 0; v < 256; v += 17) begin
      status_in = {8'(~v), 8'(v)};
      rd_bus(3'b010, d);
      chk("R5 low byte", {8'h0, d}, {8'h0, 8'(v)});
      rd_bus(3'b010, d);
      chk("R5 R3 high byte after toggle", {8'h0, d}, {8'h0, 8'(~v)});
    end

    // R6: lock low reads zero, pointer still toggles
    status_in = 16'h3CC3;
    pll_lock = 1'b0;
    rd_bus(3'b010, d);
    chk("R6 read with lock low", {8'h0, d}, 16'h0);
    pll_lock = 1'b1;
    rd_bus(3'b010, d);
    chk("R6 pointer toggled during unlocked read", {8'h0, d}, 16'h003C);

    // R7: lock gates interrupts
    status_in = 16'hFFFF;
    pll_lock = 1'b0;
    #1 chk("R7 irqs low without lock", {13'h0, irq_demod, irq_fec, irq_any}, 16'h0);
    pll_lock = 1'b1;
    #1 chk("R7 irqs with lock", {13'h0, irq_demod, irq_fec, irq_any},
           {13'h0, |exp_mode[15:8], |exp_mode[7:0], |exp_mode});

    // R8: other addresses leave mode and pointer alone
    wr_bus(3'b001, 8'h00);
    for (int a = 0; a < 8; a++) begin
      if (a != 1 && a != 2) begin
        wr_bus(3'(a), 8'hFF);
        rd_bus(3'(a), d);
        chk("R9 rdata on other address", {8'h0, d}, 16'h0);
      end
    end
    sweep_mode("R8 mode unchanged");
    status_in = 16'h7E81;
    rd_bus(3'b010, d);
    chk("R8 pointer unchanged", {8'h0, d}, 16'h0081);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule